// File: doc/BRIEF.md
# Table-Driven Montgomery Modular Multiplier

This block computes the Montgomery product P = X·Y·2^(-n) mod M for an odd modulus M and operands 0 ≤ X, Y < M. Here n is the operand width, a parameter of the block. A host drives X, Y and M in parallel and raises `start` for one cycle. The block then works on its own, shows `busy`, and pulses `done` when `pOut` holds the reduced product.

Each loop iteration uses a single carry-save addition on a redundant sum/carry pair. Before the loop, Y+M is formed once with an ordinary adder. Each iteration then chooses one addend from {0, M, Y, Y+M}. The choice depends on the current multiplier bit and on the parity of the sum and carry words, taken with the low bit of Y. This keeps the running value even so that it can be halved exactly.

After n iterations, one carry-propagate addition merges the pair. A single conditional subtraction of M then brings the result into range.

Top module: `montmul_top`

## Requirements
- R1: While reset is asserted and after its release, until the first accepted start, `busy` and `done` are 0 and `pOut` is 0.
- R2: For any odd M and any X, Y < M, the value in `pOut` at `done` equals X·Y·2^(-n) mod M, where n is the operand width.
- R3: A start accepted at a rising edge makes `busy` 1 from that edge on. `done` is a one-cycle pulse that rises on the (n+3)-th rising edge after the accepting edge. `busy` falls on that same edge.
- R4: A `start` raised while `busy` is 1 has no effect: no extra `done` pulse follows, and the result is that of the operation already running.
- R5: X, Y and M are captured on the edge that accepts start. Changes on `xIn`, `yIn` and `mIn` after that edge do not alter the result.
- R6: `pOut` changes only on the edge where `done` rises. Otherwise it holds its last value.
- R7: The final correction tests merged value ≥ M, so every result satisfies 0 ≤ P < M. This holds when an operand is M−1 and when M = 1.
- R8: An operand of zero gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when not busy |
| xIn | input | OP_W | Multiplier X, consumed from its LSB upward |
| yIn | input | OP_W | Multiplicand Y |
| mIn | input | OP_W | Odd modulus M |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `pOut` holds a new result |
| pOut | output | OP_W | Reduced Montgomery product |

## Verification
A 4-bit instance is swept over every odd modulus and over every X, Y below it. All four addend choices are hit together with every parity of the redundant pair, and both outcomes of the final subtraction are covered. A wrong addend rule or a lost carry bit shows up as a mismatch against the arithmetic model. A 16-bit instance is driven with zero operands, with M−1 operands on the largest modulus, and with scattered values. This exposes faults that only appear at the full width of the sum and carry words. Inputs are scrambled right after each start, and a second start is raised mid-run. This separates true operand capture and start masking from designs that merely happen to read stable inputs.

// File: rtl/montmul_pkg.sv
package montmul_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch operands
    logic prep;     // form Y+M, clear sum/carry pair
    logic step;     // one carry-save iteration
    logic fold;     // carry-propagate merge
    logic trim;     // conditional subtract, update result
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ADD_ZERO = 2'd0,
    ADD_MOD  = 2'd1,
    ADD_MULT = 2'd2,
    ADD_BOTH = 2'd3
  } addSel_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_ITER = 3'd2,
    ST_FOLD = 3'd3,
    ST_TRIM = 3'd4
  } seqState_t;

endpackage

// File: rtl/montmul_csa.sv
module montmul_csa #(
  parameter int W = 18
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  output logic [W-1:0] sumW,
  output logic [W-1:0] majW
);
  // independent full adders, no carry chain between bit positions
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sumW[i] = opA[i] ^ opB[i] ^ opC[i];
    assign majW[i] = (opA[i] & opB[i]) | (opA[i] & opC[i]) | (opB[i] & opC[i]);
  end
endmodule

// File: rtl/montmul_ctrl.sv
module montmul_ctrl
  import montmul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(OP_W + 1);
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(OP_W - 1);

  seqState_t state, stateNxt;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobe.capture = 1'b1;
        stateNxt       = ST_PREP;
      end
      ST_PREP: begin
        strobe.prep = 1'b1;
        stateNxt    = ST_ITER;
      end
      ST_ITER: begin
        strobe.step = 1'b1;
        if (iterCnt == LAST_ITER) stateNxt = ST_FOLD;
      end
      ST_FOLD: begin
        strobe.fold = 1'b1;
        stateNxt    = ST_TRIM;
      end
      ST_TRIM: begin
        strobe.trim = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_TRIM);
      if (state == ST_PREP)      iterCnt <= '0;
      else if (state == ST_ITER) iterCnt <= iterCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/montmul_dpath.sv
module montmul_dpath
  import montmul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [OP_W-1:0] xIn,
  input  logic [OP_W-1:0] yIn,
  input  logic [OP_W-1:0] mIn,
  output logic [OP_W-1:0] pOut,
  output logic [OP_W+1:0] mHeld
);
  // two guard bits: the redundant pair stays below 4M
  localparam int ACC_W = OP_W + 2;

  logic [OP_W-1:0]  xSh;
  logic [ACC_W-1:0] yHeld, rSum, sAcc, cAcc, foldSum;
  logic [ACC_W-1:0] addend, csaSum, csaMaj, diff;
  logic [OP_W-1:0]  pReg;
  logic             pairOdd;
  addSel_t          sel;

  // addend choice from multiplier bit and pair parity
  always_comb begin
    pairOdd = sAcc[0] ^ cAcc[0];
    if (!xSh[0]) sel = pairOdd ? ADD_MOD : ADD_ZERO;
    else         sel = (pairOdd ^ yHeld[0]) ? ADD_BOTH : ADD_MULT;
    unique case (sel)
      ADD_ZERO: addend = '0;
      ADD_MOD:  addend = mHeld;
      ADD_MULT: addend = yHeld;
      default:  addend = rSum;
    endcase
  end

  montmul_csa #(.W(ACC_W)) csaI (
    .opA (sAcc),
    .opB (cAcc),
    .opC (addend),
    .sumW(csaSum),
    .majW(csaMaj)
  );

  assign diff = foldSum - mHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xSh     <= '0;
      yHeld   <= '0;
      mHeld   <= '0;
      rSum    <= '0;
      sAcc    <= '0;
      cAcc    <= '0;
      foldSum <= '0;
      pReg    <= '0;
    end else begin
      if (strobe.capture) begin
        xSh   <= xIn;
        yHeld <= {2'b00, yIn};
        mHeld <= {2'b00, mIn};
      end
      if (strobe.prep) begin
        rSum <= yHeld + mHeld;
        sAcc <= '0;
        cAcc <= '0;
      end
      if (strobe.step) begin
        // sum word is even here; carry word halved is the majority vector
        sAcc <= csaSum >> 1;
        cAcc <= csaMaj;
        xSh  <= xSh >> 1;
      end
      if (strobe.fold) foldSum <= sAcc + cAcc;
      if (strobe.trim) pReg <= (foldSum >= mHeld) ? diff[OP_W-1:0] : foldSum[OP_W-1:0];
    end
  end

  assign pOut = pReg;
endmodule

// File: rtl/montmul_top.sv
module montmul_top
  import montmul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] xIn,
  input  logic [OP_W-1:0] yIn,
  input  logic [OP_W-1:0] mIn,
  output logic            busy,
  output logic            done,
  output logic [OP_W-1:0] pOut
);
  dpStrobe_t       strobe;
  logic [OP_W+1:0] mHeld;

  montmul_ctrl #(.OP_W(OP_W)) ctrlI (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  montmul_dpath #(.OP_W(OP_W)) dpathI (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .xIn   (xIn),
    .yIn   (yIn),
    .mIn   (mIn),
    .pOut  (pOut),
    .mHeld (mHeld)
  );
endmodule

// File: rtl/montmul_chk.sv
module montmul_chk #(
  parameter int OP_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [OP_W-1:0] pOut,
  input logic [OP_W+1:0] mHeld
);
  localparam int BC_W = $clog2(OP_W + 4) + 1;
  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyCnt == BC_W'(OP_W + 3));
  // R7
  p_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> {2'b00, pOut} < mHeld);
  // R6
  p_hold_chk: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(pOut));
  // R4
  start_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

bind montmul_top montmul_chk #(.OP_W(OP_W)) chkI (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .busy (busy),
  .done (done),
  .pOut (pOut),
  .mHeld(mHeld)
);

// File: tb/montmul_top_test.sv
module montmul_top_test;
  localparam int SW = 4;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          sStart = 1'b0, sBusy, sDone;
  logic [SW-1:0] sX = '0, sY = '0, sM = '0, sP;
  logic          wStart = 1'b0, wBusy, wDone;
  logic [WW-1:0] wX = '0, wY = '0, wM = '0, wP;

  int total = 0;
  int bad = 0;

  montmul_top #(.OP_W(SW)) uut (
    .clk(clk), .rstN(rstN), .start(sStart), .xIn(sX), .yIn(sY), .mIn(sM),
    .busy(sBusy), .done(sDone), .pOut(sP));

  montmul_top #(.OP_W(WW)) uutWide (
    .clk(clk), .rstN(rstN), .start(wStart), .xIn(wX), .yIn(wY), .mIn(wM),
    .busy(wBusy), .done(wDone), .pOut(wP));

  function automatic longint refMont(longint x, longint y, longint m, int n);
    longint r = (x * y) % m;
    for (int i = 0; i < n; i++) begin
      if (r[0]) r = r + m;
      r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runSmall(int x, int y, int m);
    int cyc = 0;
    @(negedge clk);
    sX = SW'(x); sY = SW'(y); sM = SW'(m); sStart = 1'b1;
    @(negedge clk);
    cyc = 1;
    sStart = 1'b0;
    // R5: scramble inputs once captured
    sX = ~SW'(x); sY = ~SW'(y); sM = SW'(m + 6);
    while (!sDone && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    check("R3 latency", cyc, SW + 4);
    check("R2 R5 product", sP, refMont(x, y, m, SW));
    if (sP >= SW'(m)) check("R7 range", sP, m - 1);
  endtask

  task automatic runWide(int x, int y, int m, string tag);
    int cyc = 0;
    @(negedge clk);
    wX = WW'(x); wY = WW'(y); wM = WW'(m); wStart = 1'b1;
    @(negedge clk);
    cyc = 1;
    wStart = 1'b0;
    check("R3 busy raised", wBusy, 1);
    wX = 16'h5A5A; wY = 16'hA5A5; wM = 16'h0003;
    while (!wDone && cyc < 80) begin
      @(negedge clk);
      cyc++;
    end
    check("R3 wide latency", cyc, WW + 4);
    check(tag, wP, refMont(x, y, m, WW));
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", sBusy, 0);
    check("R1 done in reset", wDone, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 busy idle", wBusy, 0);
    check("R1 done idle", sDone, 0);
    check("R1 result idle", wP, 0);

    // exhaustive sweep of the narrow instance
    for (int m = 1; m < (1 << SW); m += 2)
      for (int x = 0; x < m; x++)
        for (int y = 0; y < m; y++)
          runSmall(x, y, m);

    // directed wide cases
    runWide(0, 12345, 65535, "R8 zero multiplier");
    runWide(40000, 0, 65521, "R8 zero multiplicand");
    runWide(65534, 65534, 65535, "R7 max operands");
    runWide(1, 1, 1, "R7 unit modulus");
    runWide(32768, 32768, 32769, "R2 power of two");
    begin
      int seed = 7;
      for (int k = 0; k < 12; k++) begin
        int m, x, y;
        seed = (seed * 1103 + 12345) % 65536;
        m = seed | 1;
        seed = (seed * 1103 + 12345) % 65536;
        x = seed % m;
        seed = (seed * 1103 + 12345) % 65536;
        y = seed % m;
        runWide(x, y, m, "R2 scattered");
      end
    end

    // R4: second start during a run is ignored
    begin
      int dones = 0;
      longint held;
      @(negedge clk);
      wX = 16'd1234; wY = 16'd4321; wM = 16'd60001; wStart = 1'b1;
      @(negedge clk);
      wStart = 1'b0;
      repeat (3) @(negedge clk);
      wX = 16'd9; wY = 16'd9; wM = 16'd11; wStart = 1'b1;
      @(negedge clk);
      wStart = 1'b0;
      for (int c = 0; c < 60 && !wDone; c++) @(negedge clk);
      check("R4 first result kept", wP, refMont(1234, 4321, 60001, WW));
      held = wP;
      @(negedge clk);
      for (int c = 0; c < 30; c++) begin
        if (wDone) dones++;
        @(negedge clk);
      end
      check("R4 no extra done", dones, 0);
      check("R6 result held", wP, held);
      check("R4 idle after", wBusy, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule